// File: doc/BRIEF.md
# Write Strobe Over-Assertion Checker

This block is a passive monitor for a memory-mapped write channel pair. It captures one write address descriptor (start address, beat size, beat count and burst kind) and then follows the write data beats of that burst. For each beat it works out which byte lanes the beat's address and size allow. It reports any beat whose strobe mask sets a lane outside that span. A strobe that covers only part of the allowed span is a legal sparse write and raises nothing. The monitor also compares the beat's end-of-burst marker with the beat that should close the burst.

Both channels are valid/ready. The monitor only observes them and never drives the ready lines. A beat or a descriptor counts only in a cycle where its valid and its ready are both high. While valid is high and ready is low, the sender is being held off, and the monitor ignores whatever strobe, last marker or descriptor is on the bus. Only one burst is tracked at a time. The first error is latched with its beat index, its offending lanes and its cause, and it stays until reset.

Top module: `wstrb_guard`

## Requirements
- R1: The permitted lanes of a beat run from lane (beat address mod bus bytes) up to, but not including, lane ((beat address rounded down to a multiple of 2^size) mod bus bytes) + 2^size. On a 4-byte bus with size 2 at address 0x02, the first beat permits lanes 2 and 3 (mask 4'b1100) and every later beat permits all four lanes.
- R2: A beat whose strobe is any subset of its permitted lanes, including the empty set, raises no error.
- R3: A beat whose strobe has a bit set outside its permitted lanes sets err_flag. err_lanes then holds exactly (strobe AND NOT permitted), and err_beat holds the beat index, starting at 0.
- R4: The burst kind is coded 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping. For a fixed burst, every beat uses the start address, so every beat has the same permitted lanes.
- R5: For an incrementing burst, beat n (n>0) has address (start rounded down to 2^size) + n*2^size, so the span of a narrow burst moves through the lanes.
- R6: For a wrapping burst of len+1 beats, beat addresses increase by 2^size inside the aligned window of (len+1)*2^size bytes and wrap to the bottom of that window.
- R7: A write data cycle with w_valid high and w_ready low is not evaluated and does not advance the beat count.
- R8: The error report is sticky until reset. Only the first failing beat is captured, and later failures leave err_beat, err_lanes and err_last unchanged.
- R9: A beat whose w_last does not match whether it is beat aw_len sets err_flag with err_last=1. A burst ends at its beat aw_len or at a beat with w_last high, whichever comes first.
- R10: After reset all error outputs are 0. An error appears on the outputs in the cycle after the handshake of the failing beat.
- R11: A data beat accepted while no burst is open is ignored. A descriptor handshake while a burst is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Descriptor valid |
| aw_ready | input | 1 | Descriptor ready |
| aw_addr | input | ADDR_W | Burst start address |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_len | input | LEN_W | Beats in burst minus one |
| aw_burst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Data beat valid |
| w_ready | input | 1 | Data beat ready |
| w_strb | input | DATA_BYTES | Observed byte strobes |
| w_last | input | 1 | Observed end-of-burst marker |
| err_flag | output | 1 | Sticky violation flag |
| err_last | output | 1 | Captured error was a last-marker mismatch |
| err_beat | output | LEN_W | Index of the first failing beat |
| err_lanes | output | DATA_BYTES | Strobe bits outside the permitted lanes on that beat |

## Verification
The hardest condition to reach from the ports is an open burst that sees a second descriptor handshake, or a stalled cycle that carries illegal strobes. Both could only corrupt state that the outputs do not show until a later beat. The stimulus offers an all-ones strobe with an early last marker during every back-pressured cycle. In one burst it also places a conflicting descriptor handshake in the same cycle as beat 0, chosen so that accepting it would move beat 1's span away from its strobe. Wrapping bursts start near the top of their window, so the wrap point falls inside the burst.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;
endpackage

// File: rtl/wsg_beat_track.sv
module wsg_beat_track #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [2:0]        ld_size,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [1:0]        ld_burst,
  input  logic              beat,
  input  logic              beat_last,
  output logic              active,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [2:0]        cur_size,
  output logic [LEN_W-1:0]  beat_idx,
  output logic              is_final
);
  import wsg_pkg::*;

  logic [LEN_W-1:0]  len_q;
  burst_e            kind_q;
  logic [ADDR_W-1:0] nb, al, wmask, nxt;

  assign is_final = (beat_idx == len_q);

  always_comb begin
    nb    = ADDR_W'(1) << cur_size;
    al    = cur_addr & ~(nb - ADDR_W'(1));
    wmask = (ADDR_W'(len_q) << cur_size) | (nb - ADDR_W'(1));
    case (kind_q)
      BURST_FIXED: nxt = cur_addr;
      BURST_WRAP:  nxt = (cur_addr & ~wmask) | ((al + nb) & wmask);
      default:     nxt = al + nb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
      cur_size <= '0;
      len_q    <= '0;
      kind_q   <= BURST_INCR;
      beat_idx <= '0;
    end else if (load) begin
      active   <= 1'b1;
      cur_addr <= ld_addr;
      cur_size <= ld_size;
      len_q    <= ld_len;
      kind_q   <= burst_e'(ld_burst);
      beat_idx <= '0;
    end else if (beat) begin
      cur_addr <= nxt;
      beat_idx <= beat_idx + LEN_W'(1);
      if (is_final || beat_last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/wsg_lane_span.sv
module wsg_lane_span #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] permit
);
  localparam int LB = $clog2(DATA_BYTES);

  logic [2:0]  eff_size;
  logic [LB:0] nb, lo, hi;
  logic [LB-1:0] base;

  always_comb begin
    eff_size = (size > 3'(LB)) ? 3'(LB) : size;
    nb       = (LB+1)'(1) << eff_size;
    base     = addr[LB-1:0] & ~LB'(nb - (LB+1)'(1));
    lo       = {1'b0, addr[LB-1:0]};
    hi       = {1'b0, base} + nb;
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign permit[g] = ((LB+1)'(g) >= lo) && ((LB+1)'(g) < hi);
  end
endmodule

// File: rtl/wsg_err_latch.sv
module wsg_err_latch #(
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eval,
  input  logic [LEN_W-1:0]      beat_idx,
  input  logic [DATA_BYTES-1:0] over,
  input  logic                  last_bad,
  output logic                  err_flag,
  output logic                  err_last,
  output logic [LEN_W-1:0]      err_beat,
  output logic [DATA_BYTES-1:0] err_lanes
);
  logic fail;
  assign fail = eval && ((|over) || last_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_last  <= 1'b0;
      err_beat  <= '0;
      err_lanes <= '0;
    end else if (fail && !err_flag) begin
      err_flag  <= 1'b1;
      err_last  <= last_bad;
      err_beat  <= beat_idx;
      err_lanes <= over;
    end
  end
endmodule

// File: rtl/wstrb_guard.sv
module wstrb_guard #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  aw_valid,
  input  logic                  aw_ready,
  input  logic [ADDR_W-1:0]     aw_addr,
  input  logic [2:0]            aw_size,
  input  logic [LEN_W-1:0]      aw_len,
  input  logic [1:0]            aw_burst,
  input  logic                  w_valid,
  input  logic                  w_ready,
  input  logic [DATA_BYTES-1:0] w_strb,
  input  logic                  w_last,
  output logic                  err_flag,
  output logic                  err_last,
  output logic [LEN_W-1:0]      err_beat,
  output logic [DATA_BYTES-1:0] err_lanes
);
  logic                  active, is_final, load, beat;
  logic [ADDR_W-1:0]     cur_addr;
  logic [2:0]            cur_size;
  logic [LEN_W-1:0]      beat_idx;
  logic [DATA_BYTES-1:0] permit, over;

  assign load = aw_valid && aw_ready && !active;
  assign beat = w_valid && w_ready && active;
  assign over = w_strb & ~permit;

  wsg_beat_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(aw_addr),
    .ld_size(aw_size), .ld_len(aw_len), .ld_burst(aw_burst),
    .beat(beat), .beat_last(w_last), .active(active),
    .cur_addr(cur_addr), .cur_size(cur_size), .beat_idx(beat_idx),
    .is_final(is_final)
  );

  wsg_lane_span #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_span (
    .addr(cur_addr), .size(cur_size), .permit(permit)
  );

  wsg_err_latch #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W)) u_err (
    .clk(clk), .rst_n(rst_n), .eval(beat), .beat_idx(beat_idx),
    .over(over), .last_bad(w_last != is_final),
    .err_flag(err_flag), .err_last(err_last), .err_beat(err_beat),
    .err_lanes(err_lanes)
  );
endmodule

// File: rtl/wsg_guard_sva.sv
module wsg_guard_sva #(
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  w_valid,
  input logic                  w_ready,
  input logic [DATA_BYTES-1:0] w_strb,
  input logic                  active,
  input logic                  err_flag,
  input logic                  err_last,
  input logic [LEN_W-1:0]      err_beat,
  input logic [DATA_BYTES-1:0] err_lanes
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R8
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> ($stable(err_beat) && $stable(err_lanes) && $stable(err_last))); // R8
  AST_CAUSE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> ((err_lanes != '0) || err_last)); // R3
  AST_LANES_FROM_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> ((err_lanes & ~$past(w_strb)) == '0)); // R3
  AST_STALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !(w_valid && w_ready)) |=> !err_flag); // R7
  AST_IDLE_BEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !active && w_valid && w_ready) |=> !err_flag); // R11
endmodule

bind wstrb_guard wsg_guard_sva #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W)) u_sva (.*);

// File: tb/wstrb_guard_tb_top.sv
`timescale 1ns/1ps
module wstrb_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic [31:0] aw_addr = '0;
  logic [2:0]  aw_size = '0;
  logic [7:0]  aw_len = '0;
  logic [1:0]  aw_burst = '0;
  logic [3:0]  w_strb = '0;
  logic        err_flag, err_last;
  logic [7:0]  err_beat;
  logic [3:0]  err_lanes;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { bit flag; bit last; int beat; logic [3:0] lanes; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  wstrb_guard dut_i (
    .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_addr(aw_addr), .aw_size(aw_size), .aw_len(aw_len), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb), .w_last(w_last),
    .err_flag(err_flag), .err_last(err_last), .err_beat(err_beat), .err_lanes(err_lanes)
  );

  task automatic check_now(string tag, bit f, bit l, int b, logic [3:0] ln);
    checks++;
    if (err_flag !== f || err_last !== l || int'(err_beat) != b || err_lanes !== ln) begin
      errors++;
      $display("FAIL %s: actual flag=%0b last=%0b beat=%0d lanes=%b expected flag=%0b last=%0b beat=%0d lanes=%b",
               tag, err_flag, err_last, err_beat, err_lanes, f, l, b, ln);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check_now(e.tag, e.flag, e.last, e.beat, e.lanes);
      end
    end
  end

  function automatic logic [3:0] permit_of(int addr, int size, int len, int kind, int n);
    int nb, a, wrap, lower, lo, hi;
    logic [3:0] m;
    nb = 1 << size;
    if (kind == 0) a = addr;
    else if (kind == 2) begin
      wrap = nb * (len + 1);
      lower = (addr / wrap) * wrap;
      a = lower + ((addr - lower) + n * nb) % wrap;
    end else a = (n == 0) ? addr : (addr / nb) * nb + n * nb;
    lo = a % 4;
    hi = ((a / nb) * nb) % 4 + nb;
    for (int k = 0; k < 4; k++) m[k] = (k >= lo) && (k < hi);
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_burst(string tag, int addr, int size, int len, int kind,
                           logic [3:0] s[16], int last_beat, bit stall, bit busy_aw);
    exp_t e;
    logic [3:0] ov;
    bit lb;
    e.flag = 0; e.last = 0; e.beat = 0; e.lanes = '0; e.tag = tag;
    for (int n = 0; n <= last_beat && n <= len; n++) begin
      ov = s[n] & ~permit_of(addr, size, len, kind, n);
      lb = (n == last_beat) != (n == len);
      if (!e.flag && (ov != 0 || lb)) begin
        e.flag = 1; e.last = lb; e.beat = n; e.lanes = ov;
      end
    end
    @(negedge clk);
    aw_addr = addr; aw_size = 3'(size); aw_len = 8'(len); aw_burst = 2'(kind);
    aw_valid = 1; aw_ready = 1;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
    for (int n = 0; n <= last_beat; n++) begin
      if (stall) begin
        w_valid = 1; w_ready = 0; w_strb = 4'hF; w_last = 1;
        @(negedge clk);
      end
      w_valid = 1; w_ready = 1; w_strb = s[n]; w_last = (n == last_beat);
      if (busy_aw && n == 0) begin
        aw_addr = 3; aw_size = 0; aw_len = 5; aw_burst = 2'b01;
        aw_valid = 1; aw_ready = 1;
      end
      @(negedge clk);
      aw_valid = 0; aw_ready = 0;
    end
    w_valid = 0; w_ready = 0; w_last = 0;
    #1 q.push_back(e);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [3:0] s[16];
    do_reset();
    @(negedge clk); #1;
    check_now("R10 reset state", 0, 0, 0, 4'b0000);

    s = '{default: 4'hF};
    do_reset(); run_burst("R5 aligned incr with stalls R7", 0, 2, 3, 1, s, 3, 1, 0);

    s = '{default: 4'hF}; s[0] = 4'b1100;
    do_reset(); run_burst("R1 unaligned 0x02 partial first", 2, 2, 2, 1, s, 2, 0, 0);

    s[0] = 4'b1110;
    do_reset(); run_burst("R1 R3 unaligned overreach", 2, 2, 2, 1, s, 2, 0, 0);

    s = '{default: 4'h0}; s[0] = 4'b0010; s[1] = 4'b0100; s[2] = 4'b1000; s[3] = 4'b0001;
    do_reset(); run_burst("R5 narrow rotate", 1, 0, 3, 1, s, 3, 0, 0);

    s = '{default: 4'h0}; s[0] = 4'b0001; s[1] = 4'b1000; s[2] = 4'b0011; s[3] = 4'b0000;
    do_reset(); run_burst("R2 sparse halfword", 0, 1, 3, 1, s, 3, 0, 0);

    s = '{default: 4'h0}; s[0] = 4'b0010; s[1] = 4'b0100; s[2] = 4'b1100; s[3] = 4'b0001;
    do_reset(); run_burst("R5 R3 narrow error beat2", 1, 0, 3, 1, s, 3, 0, 0);

    s = '{default: 4'b1100}; s[3] = 4'b0011;
    do_reset(); run_burst("R4 fixed span constant", 2, 1, 3, 0, s, 3, 0, 0);

    s = '{default: 4'h0}; s[0] = 4'b0100; s[1] = 4'b1000; s[2] = 4'b0001; s[3] = 4'b0010;
    do_reset(); run_burst("R6 wrap bytes", 6, 0, 3, 2, s, 3, 1, 0);

    s = '{default: 4'b1100};
    do_reset(); run_burst("R6 wrap halfword error", 6, 1, 1, 2, s, 1, 0, 0);

    s = '{default: 4'hF}; s[0] = 4'b0011;
    do_reset(); run_burst("R8 first error kept", 0, 0, 3, 1, s, 3, 0, 0);

    s = '{default: 4'hF};
    do_reset(); run_burst("R9 early last", 0, 2, 3, 1, s, 1, 0, 0);
    do_reset(); run_burst("R9 missing last", 0, 2, 1, 1, s, 2, 0, 0);

    s = '{default: 4'h0}; s[0] = 4'b0001; s[1] = 4'b0010;
    do_reset(); run_burst("R11 descriptor while busy", 0, 0, 1, 1, s, 1, 0, 1);

    do_reset();
    @(negedge clk); w_valid = 1; w_ready = 1; w_strb = 4'hF; w_last = 0;
    @(negedge clk); @(negedge clk); w_valid = 0;
    @(negedge clk); #1;
    check_now("R11 beat with no descriptor", 0, 0, 0, 4'b0000);

    do_reset();
    @(negedge clk); aw_addr = 2; aw_size = 2; aw_len = 0; aw_burst = 1; aw_valid = 1; aw_ready = 1;
    @(negedge clk); aw_valid = 0; aw_ready = 0;
    w_valid = 1; w_ready = 1; w_strb = 4'b0001; w_last = 1;
    #1 check_now("R10 no error before handshake edge", 0, 0, 0, 4'b0000);
    @(negedge clk); w_valid = 0; w_ready = 0; w_last = 0;
    #1 check_now("R10 error one cycle after handshake", 1, 0, 0, 4'b0001);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule